// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel bus ports, A and B, through a pair of storage registers, one for each direction of travel. Each direction forwards either the live value on the opposite port or the value held in that direction's register. An active-low enable and a direction input choose which port drives, if any. Each port is modelled as an input vector, an output vector and a per-bit output-enable vector, so a tri-state pad can be built from them at the chip edge.

The datapath is split into independent lanes (two lanes of 8 bits by default). Each lane has its own enable, direction, two source selects and two capture strobes. Tying the controls of all lanes together gives one wide transceiver. Capture strobes are sampled on the block clock, and a register loads on the rising edge of its strobe. Each source select is registered once, so a live/stored change at the outputs only ever happens at a clock edge, as one clean step.

Top module: `regbus_xcvr`

## Requirements
- R1: While rst_ni is low, every bit of a_oe_o and b_oe_o is 0 and a_o and b_o are 0. Both storage registers clear to zero, so a stored read before any capture returns 0.
- R2: In a lane, a cycle in which cap_ab_i is sampled 1 after being sampled 0 on the previous edge loads that lane's a_i into the A register at that edge.
- R3: In a lane, a sampled rising edge of cap_ba_i loads that lane's b_i into the B register at that edge.
- R4: Captures take place whatever the value of the lane's select inputs, including while that register is the selected output source.
- R5: With oe_ni high, a lane drives neither port: the output enables and outputs of that lane are all 0. Both registers still load on their strobes.
- R6: With oe_ni low, dir_i = 1 drives every bit of the lane's B port and dir_i = 0 drives every bit of its A port.
- R7: A lane never enables outputs on its A and B ports at the same time.
- R8: The lane's driven B port shows the A register when sel_ab_i = 1 and live a_i when sel_ab_i = 0. The driven A port shows the B register when sel_ba_i = 1 and live b_i when sel_ba_i = 0. A select change takes effect after the next rising clock edge. A port that is not driven outputs 0.
- R9: A driven output always equals either the live input or the register of its direction, never any other value. Before the clock edge that registers a new select value, the output keeps the previous source.
- R10: Lane k uses only bits [8k+7:8k] of the data vectors and bit k of each control vector. Its controls have no effect on any other lane.
- R11: A capture strobe held high loads its register once. A later change on the port input does not reach the register until the strobe falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; samples strobes and selects |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oe_ni | input | N_LANES | Per-lane output enable, active low |
| dir_i | input | N_LANES | Per-lane direction: 1 drives B, 0 drives A |
| sel_ab_i | input | N_LANES | B output source: 1 A register, 0 live A |
| sel_ba_i | input | N_LANES | A output source: 1 B register, 0 live B |
| cap_ab_i | input | N_LANES | Rising edge loads A register from a_i |
| cap_ba_i | input | N_LANES | Rising edge loads B register from b_i |
| a_i | input | LANE_W*N_LANES | A port input value |
| a_o | output | LANE_W*N_LANES | A port output value |
| a_oe_o | output | LANE_W*N_LANES | A port per-bit output enable |
| b_i | input | LANE_W*N_LANES | B port input value |
| b_o | output | LANE_W*N_LANES | B port output value |
| b_oe_o | output | LANE_W*N_LANES | B port per-bit output enable |

## Verification
A register that loaded the wrong value, or loaded at the wrong strobe edge, stays hidden until that lane is read in stored mode. The bench therefore reads back in recall mode one cycle after each directed capture, and the random phase often switches to stored mode. A select register that is stale or lost shows up as the wrong source on the first driven cycle after the edge. A wrong enable decode shows up in the same cycle as a port that is driven when it should not be, or as both ports driven at once. Because every driven output must equal either the live input or the register, an output mux that passes through an intermediate value fails on the cycle it happens.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  typedef enum logic {
    DIR_TO_A = 1'b0,
    DIR_TO_B = 1'b1
  } dir_e;
endpackage

// File: rtl/regbus_store.sv
// Storage register loaded on a sampled rising edge of its strobe.
module regbus_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic cap_q;
  logic load;

  assign load = cap_i & ~cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= 1'b0;
      q_o   <= '0;
    end else begin
      cap_q <= cap_i;
      if (load) q_o <= d_i;
    end
  end
endmodule

// File: rtl/regbus_path.sv
// One direction's output: the source select is registered so the mux only switches at a clock edge.
module regbus_path #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  logic         en_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] oe_o
);
  import regbus_pkg::*;

  src_e src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= SRC_LIVE;
    else         src_q <= src_e'(sel_i);
  end

  always_comb begin
    q_o = '0;
    if (en_i) q_o = (src_q == SRC_STORED) ? stored_i : live_i;
  end

  assign oe_o = {W{en_i}};
endmodule

// File: rtl/regbus_lane.sv
module regbus_lane #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         oe_ni,
  input  logic         dir_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic         cap_ab_i,
  input  logic         cap_ba_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o
);
  import regbus_pkg::*;

  logic [W-1:0] reg_a;
  logic [W-1:0] reg_b;
  logic         drive_a;
  logic         drive_b;

  // reset gates the enables so nothing drives while it is held
  assign drive_b = rst_ni & ~oe_ni & (dir_e'(dir_i) == DIR_TO_B);
  assign drive_a = rst_ni & ~oe_ni & (dir_e'(dir_i) == DIR_TO_A);

  regbus_store #(.W(W)) u_store_a (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (cap_ab_i),
    .d_i   (a_i),
    .q_o   (reg_a)
  );

  regbus_store #(.W(W)) u_store_b (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (cap_ba_i),
    .d_i   (b_i),
    .q_o   (reg_b)
  );

  regbus_path #(.W(W)) u_path_ab (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_ab_i),
    .en_i    (drive_b),
    .live_i  (a_i),
    .stored_i(reg_a),
    .q_o     (b_o),
    .oe_o    (b_oe_o)
  );

  regbus_path #(.W(W)) u_path_ba (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (sel_ba_i),
    .en_i    (drive_a),
    .live_i  (b_i),
    .stored_i(reg_b),
    .q_o     (a_o),
    .oe_o    (a_oe_o)
  );
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned N_LANES = 2,
  localparam int unsigned DW     = LANE_W * N_LANES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LANES-1:0] oe_ni,
  input  logic [N_LANES-1:0] dir_i,
  input  logic [N_LANES-1:0] sel_ab_i,
  input  logic [N_LANES-1:0] sel_ba_i,
  input  logic [N_LANES-1:0] cap_ab_i,
  input  logic [N_LANES-1:0] cap_ba_i,
  input  logic [DW-1:0]      a_i,
  output logic [DW-1:0]      a_o,
  output logic [DW-1:0]      a_oe_o,
  input  logic [DW-1:0]      b_i,
  output logic [DW-1:0]      b_o,
  output logic [DW-1:0]      b_oe_o
);
  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    regbus_lane #(.W(LANE_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .oe_ni   (oe_ni[l]),
      .dir_i   (dir_i[l]),
      .sel_ab_i(sel_ab_i[l]),
      .sel_ba_i(sel_ba_i[l]),
      .cap_ab_i(cap_ab_i[l]),
      .cap_ba_i(cap_ba_i[l]),
      .a_i     (a_i[l*LANE_W +: LANE_W]),
      .b_i     (b_i[l*LANE_W +: LANE_W]),
      .a_o     (a_o[l*LANE_W +: LANE_W]),
      .a_oe_o  (a_oe_o[l*LANE_W +: LANE_W]),
      .b_o     (b_o[l*LANE_W +: LANE_W]),
      .b_oe_o  (b_oe_o[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/regbus_lane_chk.sv
module regbus_lane_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         oe_ni,
  input logic         dir_i,
  input logic         cap_ab_i,
  input logic         cap_ba_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] a_o,
  input logic [W-1:0] a_oe_o,
  input logic [W-1:0] b_o,
  input logic [W-1:0] b_oe_o,
  input logic [W-1:0] reg_a_i,
  input logic [W-1:0] reg_b_i
);
  always_comb begin
    if (!rst_ni) begin
      a_r1_quiet_in_reset: assert (a_oe_o == '0 && b_oe_o == '0 && a_o == '0 && b_o == '0);
    end
  end

  a_r7_one_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|a_oe_o) && (|b_oe_o)));

  a_r5_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (a_oe_o == '0 && b_oe_o == '0 && a_o == '0 && b_o == '0));

  a_r6_drive_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni && dir_i) |-> (b_oe_o == '1));

  a_r6_drive_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni && !dir_i) |-> (a_oe_o == '1));

  a_r2_load_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cap_ab_i) |=> (reg_a_i == $past(a_i)));

  a_r3_load_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cap_ba_i) |=> (reg_b_i == $past(b_i)));

  a_r11_hold_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(cap_ab_i) |=> $stable(reg_a_i));

  a_r11_hold_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(cap_ba_i) |=> $stable(reg_b_i));

  a_r9_clean_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_oe_o[0] |-> (b_o == a_i || b_o == reg_a_i));

  a_r9_clean_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_oe_o[0] |-> (a_o == b_i || a_o == reg_b_i));
endmodule

bind regbus_lane regbus_lane_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .oe_ni   (oe_ni),
  .dir_i   (dir_i),
  .cap_ab_i(cap_ab_i),
  .cap_ba_i(cap_ba_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .a_o     (a_o),
  .a_oe_o  (a_oe_o),
  .b_o     (b_o),
  .b_oe_o  (b_oe_o),
  .reg_a_i (reg_a),
  .reg_b_i (reg_b)
);

// File: tb/sim_regbus_xcvr.sv
`timescale 1ns/1ps
module sim_regbus_xcvr;
  localparam int W  = 8;
  localparam int N  = 2;
  localparam int DW = W * N;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [N-1:0]  oe_n, dir, sel_ab, sel_ba, cap_ab, cap_ba;
  logic [DW-1:0] a_in, b_in;
  logic [DW-1:0] a_out, a_oe, b_out, b_oe;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] ra [N];
  logic [W-1:0] rb [N];
  logic [N-1:0] pab, pba, qab, qba;

  always #4 clk = ~clk;

  regbus_xcvr #(.LANE_W(W), .N_LANES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .oe_ni(oe_n), .dir_i(dir),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .cap_ab_i(cap_ab), .cap_ba_i(cap_ba),
    .a_i(a_in), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_o(b_out), .b_oe_o(b_oe)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_b(int l);
    if (!rst_ni || oe_n[l] || !dir[l]) return '0;
    return qab[l] ? ra[l] : a_in[l*W +: W];
  endfunction

  function automatic logic [W-1:0] exp_a(int l);
    if (!rst_ni || oe_n[l] || dir[l]) return '0;
    return qba[l] ? rb[l] : b_in[l*W +: W];
  endfunction

  task automatic model_edge();
    for (int l = 0; l < N; l++) begin
      if (!rst_ni) begin
        ra[l] = '0; rb[l] = '0;
        pab[l] = 0; pba[l] = 0; qab[l] = 0; qba[l] = 0;
      end else begin
        if (cap_ab[l] && !pab[l]) ra[l] = a_in[l*W +: W];
        if (cap_ba[l] && !pba[l]) rb[l] = b_in[l*W +: W];
        pab[l] = cap_ab[l]; pba[l] = cap_ba[l];
        qab[l] = sel_ab[l]; qba[l] = sel_ba[l];
      end
    end
  endtask

  // one clock: model follows the edge, then settle on the falling edge
  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic check_all();
    for (int l = 0; l < N; l++) begin
      logic drv_b, drv_a;
      drv_b = rst_ni && !oe_n[l] && dir[l];
      drv_a = rst_ni && !oe_n[l] && !dir[l];
      chk("R6 b_oe", 64'(b_oe[l*W +: W]), 64'({W{drv_b}}));
      chk("R6 a_oe", 64'(a_oe[l*W +: W]), 64'({W{drv_a}}));
      chk("R8 b_out", 64'(b_out[l*W +: W]), 64'(exp_b(l)));
      chk("R8 a_out", 64'(a_out[l*W +: W]), 64'(exp_a(l)));
      chk("R7 exclusive", 64'((|a_oe[l*W +: W]) && (|b_oe[l*W +: W])), 64'(0));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_ni = 0;
    oe_n = '0; dir = '1; sel_ab = '0; sel_ba = '0; cap_ab = '0; cap_ba = '0;
    a_in = 16'h5A5A; b_in = 16'hC3C3;
    for (int l = 0; l < N; l++) begin ra[l] = '0; rb[l] = '0; end
    pab = '0; pba = '0; qab = '0; qba = '0;
    cyc(); cyc();
    // R1: nothing driven in reset even though enabled
    chk("R1 b_oe", 64'(b_oe), 64'(0));
    chk("R1 a_oe", 64'(a_oe), 64'(0));
    chk("R1 b_out", 64'(b_out), 64'(0));
    rst_ni = 1;
    sel_ab = '1;
    cyc(); #1;
    // R1: cleared register read in stored mode
    chk("R1 stored zero", 64'(b_out), 64'(0));
    check_all();

    // R2/R4: load A lane 0 while stored mode selected
    a_in[7:0] = 8'hA5; cap_ab[0] = 1;
    cyc(); #1;
    chk("R4 recall shows new load", 64'(b_out[7:0]), 64'h00A5);
    cap_ab[0] = 0; a_in[7:0] = 8'h3C;
    cyc(); #1;
    chk("R2 stored A", 64'(b_out[7:0]), 64'h00A5);
    check_all();

    // R11: strobe held high loads only once
    a_in[7:0] = 8'h11; cap_ab[0] = 1;
    cyc();
    a_in[7:0] = 8'h22;
    cyc(); cyc(); #1;
    chk("R11 held strobe", 64'(b_out[7:0]), 64'h0011);
    cap_ab[0] = 0;
    cyc();

    // R9/R8: select change steps only at the edge
    sel_ab[0] = 0; #1;
    chk("R9 before edge", 64'(b_out[7:0]), 64'h0011);
    cyc(); #1;
    chk("R8 live A", 64'(b_out[7:0]), 64'h0022);
    a_in[7:0] = 8'h77; #1;
    chk("R8 live follows", 64'(b_out[7:0]), 64'h0077);
    check_all();

    // R3: B register to A port
    dir = '0; sel_ba = '1; b_in[7:0] = 8'hC3; cap_ba[0] = 1;
    cyc(); cap_ba[0] = 0; b_in[7:0] = 8'h0F;
    cyc(); #1;
    chk("R3 stored B", 64'(a_out[7:0]), 64'h00C3);
    chk("R3 B not driven", 64'(b_oe[7:0]), 64'h0);
    check_all();

    // R5: isolated, both registers still load
    oe_n = '1; a_in[7:0] = 8'h9E; b_in[7:0] = 8'h4D; cap_ab[0] = 1; cap_ba[0] = 1; #1;
    chk("R5 a_oe off", 64'(a_oe), 64'h0);
    chk("R5 b_oe off", 64'(b_oe), 64'h0);
    chk("R5 outputs zero", 64'({a_out, b_out}), 64'h0);
    cyc(); cap_ab[0] = 0; cap_ba[0] = 0; a_in[7:0] = 8'h01; b_in[7:0] = 8'h02;
    cyc();
    oe_n = '0; dir = '0; #1;
    chk("R5 B loaded isolated", 64'(a_out[7:0]), 64'h004D);
    dir = '1; sel_ab = '1;
    cyc(); #1;
    chk("R5 A loaded isolated", 64'(b_out[7:0]), 64'h009E);

    // R10: lanes run on separate controls
    dir = 2'b01; oe_n = 2'b00; sel_ab = 2'b00; sel_ba = 2'b00;
    a_in = 16'hBEEF; b_in = 16'h1234;
    cyc(); #1;
    chk("R10 lane0 to B", 64'(b_out[7:0]), 64'h00EF);
    chk("R10 lane1 to A", 64'(a_out[15:8]), 64'h0012);
    chk("R10 lane1 B idle", 64'(b_oe[15:8]), 64'h0);
    chk("R10 lane0 A idle", 64'(a_oe[7:0]), 64'h0);
    check_all();

    // random phase
    for (int i = 0; i < 3000; i++) begin
      oe_n   = N'($urandom_range(0, 7) == 0 ? $urandom : 0);
      dir    = N'($urandom);
      sel_ab = N'($urandom);
      sel_ba = N'($urandom);
      cap_ab = N'($urandom);
      cap_ba = N'($urandom);
      a_in   = DW'($urandom);
      b_in   = DW'($urandom);
      #1; check_all();
      cyc(); #1;
      check_all();
    end

    // R1: reset mid-run clears registers
    rst_ni = 0; #1;
    chk("R1 async quiet", 64'({a_oe, b_oe}), 64'h0);
    cyc();
    rst_ni = 1; oe_n = '0; dir = '1; sel_ab = '1; cap_ab = '0; cap_ba = '0;
    cyc(); #1;
    chk("R1 cleared after run", 64'(b_out), 64'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule